// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter Timer

This block is a 32-bit down-counter with a compare-match interrupt. Software drives it through a simple word-indexed read/write port with five locations: control, status, load, compare and a read-only live count. Each tick of the counter comes from one of two tick-enable inputs, a fast one and a slow one. A control field selects the source, and a 12-bit divider slows it down. A selection of "no source" stops the count.

The counter has two modes. In reload mode it wraps from zero to the programmed load value. In free-running mode it wraps from zero to all ones. When a tick brings the count onto the compare value, a sticky flag is set. This happens only while the timer and its compare interrupt are both enabled. The flag drives a level interrupt and is cleared by writing one to it.

Three control actions act at once:
- Setting the enable bit from off to on, with the start-mode bit set, preloads the count.
- Setting the overwrite bit makes a load write replace the count immediately.
- Writing the self-reset bit returns the block to its defaults, except for a small set of control bits that it keeps.

Top module: `tick_down_timer`

## Requirements
- R1: After reset the locations read as follows: control 0, status 0, load 0xFFFFFFFF, compare 0, count 0xFFFFFFFF. The interrupt is low.
- R2: The port is word-indexed. Index 0 is control, 1 is status, 2 is load, 3 is compare and 4 is count. A control write stores bits 25:0 only, so bits 31:26 read as zero. Indices 5 to 7 read as zero.
- R3: Control bits 15:4 hold the divider D. Bits 25:24 select the source: 00 none, 01 or 10 the fast tick, 11 the slow tick. While the timer is enabled, the count falls by one every D+1 ticks of the selected source. With source 00 it does not move.
- R4: Control bit 0 is enable. While it is clear the count holds its value. Writes to index 4 are ignored.
- R5: Bit 1 is start-mode and bit 3 is reload. When a control write sets enable that was clear, and start-mode is set, the count becomes the load value if reload is set and 0xFFFFFFFF otherwise. With start-mode clear, the count resumes from its held value.
- R6: A tick at count zero wraps the count to the load value in reload mode. Outside reload mode it wraps to 0xFFFFFFFF.
- R7: Control bit 17 is overwrite. A load write with overwrite set replaces the count at once, in either mode. Without overwrite the count is left as it is, and in reload mode the new value is used at the next wrap.
- R8: Bit 2 is compare-interrupt enable. A tick that makes the count equal to compare sets status bit 0, but only while enable and bit 2 are both set. The flag then holds.
- R9: Writing status with bit 0 at one clears the flag. Writing it with bit 0 at zero leaves the flag unchanged. A match in the same cycle as a clear wins, and the flag stays set.
- R10: The interrupt output is high exactly when the flag, enable and compare-interrupt enable are all set.
- R11: A control write with bit 16 set resets the block. Control keeps only bits 0, 1 and 18 to 21 of the written value. Load becomes 0xFFFFFFFF, compare 0, the flag 0 and the count 0xFFFFFFFF.
- R12: A read strobe captures the addressed location. The value appears on the read data output after the next clock edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_tick | input | 1 | Fast count-source enable, one clock wide per tick |
| slow_tick | input | 1 | Slow count-source enable, one clock wide per tick |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The effects of a write land on the first clock edge after the strobe: the stored registers, the start or overwrite preload, the self-reset, the flag clear and the interrupt level. Each source tick presented in a cycle moves the count, and sets the flag on a match, at that same edge. A read returns, after the next edge, the value the location held before that edge. The bench therefore drives every strobe and tick at the falling edge and keeps the tick inputs low between steps, so the count cannot drift. It samples read data and the interrupt at the following falling edge, exactly one rising edge later. A separate check looks at the read data just before that edge to confirm the one-cycle latency.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 26;

  localparam logic [ADDR_W-1:0] IDX_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] IDX_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] IDX_LOAD = 3'd2;
  localparam logic [ADDR_W-1:0] IDX_CMP  = 3'd3;
  localparam logic [ADDR_W-1:0] IDX_CNT  = 3'd4;

  // control bit positions (decoded by software, so fixed)
  localparam int B_EN     = 0;
  localparam int B_MODE   = 1;
  localparam int B_CIE    = 2;
  localparam int B_RLD    = 3;
  localparam int B_PRE_LO = 4;
  localparam int B_SRST   = 16;
  localparam int B_OVW    = 17;
  localparam int B_SRC_LO = 24;

  // bits surviving a self-reset: enable, start-mode, bits 21:18
  localparam logic [CTRL_W-1:0] SRST_KEEP = 26'h03C_0003;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'b00,
    SRC_FAST_A = 2'b01,
    SRC_FAST_B = 2'b10,
    SRC_SLOW   = 2'b11
  } src_e;
endpackage

// File: rtl/tdt_prescale.sv
module tdt_prescale
  import tdt_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  src_e             src_i,
  input  logic             fast_tick_i,
  input  logic             slow_tick_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic             src_tick;
  logic             step;
  logic             div_hit;

  always_comb begin
    case (src_i)
      SRC_FAST_A, SRC_FAST_B: src_tick = fast_tick_i;
      SRC_SLOW:               src_tick = slow_tick_i;
      default:                src_tick = 1'b0;
    endcase
  end

  assign step    = run_i && src_tick;
  assign div_hit = (pre_q >= div_i);
  assign tick_o  = step && div_hit;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      pre_q <= '0;
    end else if (step) begin
      pre_q <= div_hit ? '0 : pre_q + 1'b1;
    end
  end

  assert_nosrc_R3: assert property (@(posedge clk) disable iff (rst)
    (src_i == SRC_NONE) |-> !tick_o);
  assert_divgap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_o && div_i != '0 && run_i) |=> !tick_o);
endmodule

// File: rtl/tdt_count.sv
module tdt_count #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              swrst_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] start_val_i,
  input  logic              force_i,
  input  logic [DATA_W-1:0] force_val_i,
  input  logic              reload_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic [DATA_W-1:0] cmp_val_i,
  input  logic              match_en_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              match_o
);
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] dec_val;
  logic [DATA_W-1:0] wrap_val;
  logic              apply_tick;

  assign wrap_val   = reload_i ? load_val_i : '1;
  assign dec_val    = (cnt_q == '0) ? wrap_val : cnt_q - 1'b1;
  assign apply_tick = tick_i && run_i && !swrst_i && !start_i && !force_i;
  assign match_o    = apply_tick && match_en_i && (dec_val == cmp_val_i);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || swrst_i) begin
      cnt_q <= '1;
    end else if (start_i) begin
      cnt_q <= start_val_i;
    end else if (force_i) begin
      cnt_q <= force_val_i;
    end else if (apply_tick) begin
      cnt_q <= dec_val;
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!(tick_i && run_i) && !swrst_i && !start_i && !force_i) |=> $stable(cnt_q));
  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (tick_i && run_i && !swrst_i && !start_i && !force_i && cnt_q == '0)
    |=> (cnt_q == ($past(reload_i) ? $past(load_val_i) : '1)));
  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && run_i && !swrst_i && !start_i && !force_i && cnt_q != '0)
    |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_start_R5: assert property (@(posedge clk) disable iff (rst)
    (start_i && !swrst_i) |=> (cnt_q == $past(start_val_i)));
endmodule

// File: rtl/tdt_regs.sv
module tdt_regs
  import tdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              match_i,
  output logic              en_o,
  output logic              cie_o,
  output logic              rld_o,
  output logic [PRE_W-1:0]  div_o,
  output src_e              src_o,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] cmp_o,
  output logic              swrst_o,
  output logic              start_o,
  output logic [DATA_W-1:0] start_val_o,
  output logic              force_o,
  output logic [DATA_W-1:0] force_val_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] load_q, load_d;
  logic [DATA_W-1:0] cmp_q, cmp_d;
  logic              flag_q, flag_d;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;
  logic              wr_ctrl, wr_stat, wr_load, wr_cmp;

  assign wr_ctrl = wr_i && (addr_i == IDX_CTRL);
  assign wr_stat = wr_i && (addr_i == IDX_STAT);
  assign wr_load = wr_i && (addr_i == IDX_LOAD);
  assign wr_cmp  = wr_i && (addr_i == IDX_CMP);

  assign swrst_o     = wr_ctrl && wdata_i[B_SRST];
  assign start_o     = wr_ctrl && !swrst_o && wdata_i[B_EN] && !ctrl_q[B_EN] && wdata_i[B_MODE];
  assign start_val_o = wdata_i[B_RLD] ? load_q : '1;
  assign force_o     = wr_load && ctrl_q[B_OVW];
  assign force_val_o = wdata_i;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = swrst_o ? (wdata_i[CTRL_W-1:0] & SRST_KEEP) : wdata_i[CTRL_W-1:0];
    end
    if (swrst_o)      load_d = '1;
    else if (wr_load) load_d = wdata_i;
    else              load_d = load_q;
    if (swrst_o)      cmp_d = '0;
    else if (wr_cmp)  cmp_d = wdata_i;
    else              cmp_d = cmp_q;
    if (swrst_o)                      flag_d = 1'b0;
    else if (match_i)                 flag_d = 1'b1;
    else if (wr_stat && wdata_i[0])   flag_d = 1'b0;
    else                              flag_d = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '1;
      cmp_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      cmp_q  <= cmp_d;
      flag_q <= flag_d;
      irq_q  <= flag_d && ctrl_d[B_EN] && ctrl_d[B_CIE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      case (addr_i)
        IDX_CTRL: rdata_q <= DATA_W'(ctrl_q);
        IDX_STAT: rdata_q <= DATA_W'(flag_q);
        IDX_LOAD: rdata_q <= load_q;
        IDX_CMP:  rdata_q <= cmp_q;
        IDX_CNT:  rdata_q <= cnt_i;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
  assign en_o    = ctrl_q[B_EN];
  assign cie_o   = ctrl_q[B_CIE];
  assign rld_o   = ctrl_q[B_RLD];
  assign div_o   = ctrl_q[B_PRE_LO +: PRE_W];
  assign src_o   = src_e'(ctrl_q[B_SRC_LO +: 2]);
  assign load_o  = load_q;
  assign cmp_o   = cmp_q;

  assert_set_R8: assert property (@(posedge clk) disable iff (rst)
    match_i |=> flag_q);
  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && wdata_i[0] && !match_i) |=> !flag_q);
  assert_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !wdata_i[0] && flag_q) |=> flag_q);
  assert_irqflag_R10: assert property (@(posedge clk) disable iff (rst)
    !flag_q |-> !irq_q);
  assert_swrst_R11: assert property (@(posedge clk) disable iff (rst)
    swrst_o |=> (load_q == '1 && cmp_q == '0 && !flag_q && !ctrl_q[B_SRST]));
  assert_rdlat_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i == IDX_LOAD) |=> (rdata_o == $past(load_q)));
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              en, cie, rld, swrst, start, force_ld, tick, match;
  logic [PRE_W-1:0]  div;
  src_e              src;
  logic [DATA_W-1:0] load_val, cmp_val, start_val, force_val, cnt;

  tdt_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .rdata_o(bus_rdata), .irq_o(irq),
    .cnt_i(cnt), .match_i(match),
    .en_o(en), .cie_o(cie), .rld_o(rld), .div_o(div), .src_o(src),
    .load_o(load_val), .cmp_o(cmp_val),
    .swrst_o(swrst), .start_o(start), .start_val_o(start_val),
    .force_o(force_ld), .force_val_o(force_val)
  );

  tdt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run_i(en), .src_i(src),
    .fast_tick_i(fast_tick), .slow_tick_i(slow_tick),
    .div_i(div), .tick_o(tick)
  );

  tdt_count #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .run_i(en),
    .swrst_i(swrst), .start_i(start), .start_val_i(start_val),
    .force_i(force_ld), .force_val_i(force_val),
    .reload_i(rld), .load_val_i(load_val), .cmp_val_i(cmp_val),
    .match_en_i(en && cie), .cnt_o(cnt), .match_o(match)
  );

  assert_irqen_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (en && cie));
endmodule

// File: tb/tick_down_timer_tb.sv
module tick_down_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OP_WR = 0, OP_RD = 1, OP_FT = 2, OP_ST = 3, OP_IRQ = 4;
  localparam int NV = 86;

  function automatic logic [41:0] v(int op, int a, logic [31:0] d, int r);
    return {3'(op), 3'(a), d, 4'(r)};
  endfunction

  localparam logic [41:0] VEC [NV] = '{
    v(OP_RD,0,32'h0,1),        // R1 control
    v(OP_RD,1,32'h0,1),        // R1 status
    v(OP_RD,2,32'hFFFFFFFF,1), // R1 load
    v(OP_RD,3,32'h0,1),        // R1 compare
    v(OP_RD,4,32'hFFFFFFFF,1), // R1 count
    v(OP_IRQ,0,32'h0,1),       // R1 irq low
    v(OP_WR,0,32'hFF2C0000,2), // R2 upper bits dropped
    v(OP_RD,0,32'h032C0000,2), // R2
    v(OP_WR,4,32'h1234,4),     // R4 count read-only
    v(OP_RD,4,32'hFFFFFFFF,4), // R4
    v(OP_RD,6,32'h0,2),        // R2 unused index
    v(OP_WR,2,32'h64,7),       // R7 load w/o overwrite
    v(OP_RD,4,32'hFFFFFFFF,7), // R7
    v(OP_RD,2,32'h64,7),       // R7
    v(OP_WR,0,32'h0100000B,5), // R5 start, reload
    v(OP_RD,4,32'h64,5),       // R5
    v(OP_FT,0,32'd3,3),        // R3
    v(OP_RD,4,32'h61,3),       // R3
    v(OP_WR,0,32'h0100001B,3), // R3 divider 1
    v(OP_FT,0,32'd4,3),        // R3
    v(OP_RD,4,32'h5F,3),       // R3
    v(OP_WR,0,32'h0000001B,3), // R3 no source
    v(OP_FT,0,32'd5,3),        // R3
    v(OP_RD,4,32'h5F,3),       // R3
    v(OP_WR,0,32'h0300000B,3), // R3 slow source
    v(OP_FT,0,32'd2,3),        // R3 fast ignored
    v(OP_RD,4,32'h5F,3),       // R3
    v(OP_ST,0,32'd2,3),        // R3
    v(OP_RD,4,32'h5D,3),       // R3
    v(OP_WR,0,32'h0100000A,4), // R4 disable
    v(OP_FT,0,32'd3,4),        // R4
    v(OP_RD,4,32'h5D,4),       // R4 frozen
    v(OP_WR,0,32'h01000009,5), // R5 enable, start-mode clear
    v(OP_RD,4,32'h5D,5),       // R5 resumes
    v(OP_FT,0,32'd1,3),        // R3
    v(OP_RD,4,32'h5C,3),       // R3
    v(OP_WR,2,32'h2,7),        // R7 reload, no overwrite
    v(OP_RD,4,32'h5C,7),       // R7
    v(OP_WR,0,32'h01020009,7), // R7 overwrite on
    v(OP_WR,2,32'h3,7),        // R7
    v(OP_RD,4,32'h3,7),        // R7 replaced
    v(OP_FT,0,32'd3,6),        // R6
    v(OP_RD,4,32'h0,6),        // R6
    v(OP_FT,0,32'd1,6),        // R6 wrap to load
    v(OP_RD,4,32'h3,6),        // R6
    v(OP_WR,0,32'h01020001,7), // R7 free-run, overwrite
    v(OP_WR,2,32'h1,7),        // R7
    v(OP_RD,4,32'h1,7),        // R7
    v(OP_FT,0,32'd2,6),        // R6
    v(OP_RD,4,32'hFFFFFFFF,6), // R6 wrap to ones
    v(OP_WR,3,32'hFFFFFFFD,8), // R8
    v(OP_WR,0,32'h01000005,8), // R8
    v(OP_FT,0,32'd1,8),        // R8
    v(OP_RD,1,32'h0,8),        // R8 not yet
    v(OP_IRQ,0,32'h0,10),      // R10
    v(OP_FT,0,32'd1,8),        // R8 match
    v(OP_RD,1,32'h1,8),        // R8
    v(OP_IRQ,0,32'h1,10),      // R10
    v(OP_WR,1,32'h0,9),        // R9 zero write
    v(OP_RD,1,32'h1,9),        // R9
    v(OP_WR,1,32'h1,9),        // R9 clear
    v(OP_RD,1,32'h0,9),        // R9
    v(OP_IRQ,0,32'h0,10),      // R10
    v(OP_WR,3,32'hFFFFFFFB,8), // R8
    v(OP_WR,0,32'h01000001,8), // R8 cie off
    v(OP_FT,0,32'd2,8),        // R8
    v(OP_RD,4,32'hFFFFFFFB,8), // R8
    v(OP_RD,1,32'h0,8),        // R8 no flag
    v(OP_WR,3,32'hFFFFFFFA,10),// R10
    v(OP_WR,0,32'h01000005,10),// R10
    v(OP_FT,0,32'd1,10),       // R10
    v(OP_IRQ,0,32'h1,10),      // R10
    v(OP_WR,0,32'h01000001,10),// R10 cie off
    v(OP_IRQ,0,32'h0,10),      // R10
    v(OP_RD,1,32'h1,10),       // R10 flag kept
    v(OP_WR,0,32'h01000004,10),// R10 enable off
    v(OP_IRQ,0,32'h0,10),      // R10
    v(OP_WR,0,32'h01000005,10),// R10
    v(OP_IRQ,0,32'h1,10),      // R10
    v(OP_WR,0,32'h013FFFFF,11),// R11 self-reset
    v(OP_RD,0,32'h003C0003,11),// R11
    v(OP_RD,1,32'h0,11),       // R11
    v(OP_RD,2,32'hFFFFFFFF,11),// R11
    v(OP_RD,3,32'h0,11),       // R11
    v(OP_RD,4,32'hFFFFFFFF,11),// R11
    v(OP_IRQ,0,32'h0,11)       // R11
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fast_tick = 1'b0, slow_tick = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          checks = 0;
  int          bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_down_timer u_dut (
    .clk(clk), .rst(rst), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(int req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic ticks(bit slow, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (slow) slow_tick = 1'b1; else fast_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0; fast_tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    do_reset();
    for (int i = 0; i < NV; i++) begin
      automatic int          op  = int'(VEC[i][41:39]);
      automatic logic [2:0]  a   = VEC[i][38:36];
      automatic logic [31:0] d   = VEC[i][35:4];
      automatic int          req = int'(VEC[i][3:0]);
      case (op)
        OP_WR:  wr(a, d);
        OP_RD:  begin rd(a, rv); chk(req, $sformatf("vec %0d read", i), rv, d); end
        OP_FT:  ticks(1'b0, int'(d));
        OP_ST:  ticks(1'b1, int'(d));
        default: begin @(negedge clk); chk(req, $sformatf("vec %0d irq", i), {31'b0, irq}, d); end
      endcase
    end

    // R9: match and clear in the same cycle, the match wins
    wr(3'd0, 32'h01000005);
    wr(3'd3, 32'hFFFFFFFE);
    @(negedge clk);
    fast_tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 32'h1;
    @(negedge clk);
    fast_tick = 1'b0; bus_wr = 1'b0;
    rd(3'd1, rv); chk(9, "flag after match+clear", rv, 32'h1);
    rd(3'd4, rv); chk(9, "count after match tick", rv, 32'hFFFFFFFE);

    // R12: read data changes only after the edge following the strobe
    rd(3'd2, rv); chk(12, "load read", rv, 32'hFFFFFFFF);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 3'd3;
    #1 chk(12, "rdata before edge", bus_rdata, 32'hFFFFFFFF);
    @(negedge clk); bus_rd = 1'b0;
    chk(12, "rdata after edge", bus_rdata, 32'hFFFFFFFE);
    @(negedge clk);
    chk(12, "rdata holds without strobe", bus_rdata, 32'hFFFFFFFE);

    // R1: hard reset from a busy state
    do_reset();
    rd(3'd0, rv); chk(1, "ctrl after reset", rv, 32'h0);
    rd(3'd1, rv); chk(1, "status after reset", rv, 32'h0);
    rd(3'd4, rv); chk(1, "count after reset", rv, 32'hFFFFFFFF);
    chk(1, "irq after reset", {31'b0, irq}, 32'h0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule